// File: doc/BRIEF.md
# Boot Loader Command Frame Handler

This block interprets the byte stream a host sends to a boot loader. It accepts host bytes over a valid/ready byte interface and returns exactly one response byte for every byte it accepts. It recognises five command frames: a memory dump, a CRC over code space, a CRC over data space, a verify against code space and a verify against data space. It extracts address and length fields from each frame header and uses them to drive a synchronous memory read port or to start an external CRC engine. Every frame closes with a fixed marker byte.

A host clocks a complete frame through the block. The block returns zero while the header is arriving. After the pad byte it returns the requested data, and the last byte it returns is the marker. It holds `in_ready` low only while it waits on a memory read or on the CRC engine. A single input flag reports whether the loader is unlocked. A frame that arrives while the loader is locked is refused, and so is a frame with an opcode the block does not recognise. In both cases the block records an error code and discards bytes until the transport signals the end of the frame.

Top module: `ldr_frame_handler`

## Requirements
- R1: Each byte accepted (`in_valid` and `in_ready` high at a clock edge) produces exactly one response: `out_valid` is high for one cycle after that edge and is low after every edge with no accept. `in_ready` is low only while the block waits for a memory read or a CRC result.
- R2: The response to the opcode byte, to every header byte and to the pad byte is 00h.
- R3: Opcode 21h is followed by five header bytes: an ignored byte (02h), address low, address high, length low and length high. After the pad byte, the next `length` responses are data-space bytes (`mem_space`=1), read from ascending addresses starting at the given address.
- R4: Opcodes 30h and 31h use the same header as R3. After the pad byte, a nonzero length starts the CRC engine with the space (0 = code for 30h, 1 = data for 31h), the address and the length. The next two responses are the result's low byte and then its high byte.
- R5: Opcodes 40h and 41h are followed by a one-byte length, address low, address high and then `length` data bytes. Each data byte is compared with memory at ascending addresses, in code space for 40h and data space for 41h. A pad byte follows the data.
- R6: The response to the last byte of every accepted command is 3Eh.
- R7: `status` becomes 00h when a command ends with no mismatch and 01h when any verify byte differed from memory. It changes only when a command finishes or is refused.
- R8: A known opcode that arrives while `unlocked` is low sets `status` to 02h and executes nothing.
- R9: An unrecognised opcode sets `status` to 03h.
- R10: After a refusal, the block accepts every byte and answers each with 00h. It issues no memory read or CRC start until `eof_strobe` returns it to idle, and the next frame is then decoded normally.
- R11: A zero length on a dump or CRC frame produces no data bytes and no CRC start. The pad byte is followed directly by the marker. A zero-length verify frame is the pad byte followed by the marker.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| unlocked | input | 1 | Password accepted flag |
| eof_strobe | input | 1 | End-of-frame pulse from the transport |
| in_valid | input | 1 | Host byte valid |
| in_data | input | 8 | Host byte |
| in_ready | output | 1 | Block can accept a byte |
| out_valid | output | 1 | Response byte valid |
| out_data | output | 8 | Response byte |
| status | output | 8 | Result code of the last command |
| mem_rd_en | output | 1 | Memory read strobe, data returns next cycle |
| mem_space | output | 1 | 0 = code space, 1 = data space |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_rd_data | input | 8 | Memory read data |
| crc_start | output | 1 | One-cycle start pulse to the CRC engine |
| crc_space | output | 1 | Space for the CRC run |
| crc_addr | output | ADDR_W | CRC start address |
| crc_len | output | LEN_W | CRC byte count |
| crc_done | input | 1 | CRC engine finished, result valid |
| crc_result | input | CRC_W | CRC value |

## Verification
Assertions check the following on every cycle: one response follows each accepted byte, header and pad replies are zero, and the marker follows the final byte. They also check the locked and unknown-opcode status codes, that the drain state holds without an end strobe, that the CRC engine never starts with a zero length, and that status stays stable between command ends. Only the bench scenarios can show the rest, because each needs a memory and CRC model to compute expected values. These are the dumped byte values at wrapping addresses, the CRC arguments and result bytes, the mismatch detection at chosen positions, and the recovery to normal decoding after an end strobe.

// File: rtl/ldr_pkg.sv
package ldr_pkg;

  localparam logic [7:0] OP_DUMP     = 8'h21;
  localparam logic [7:0] OP_CRC_CODE = 8'h30;
  localparam logic [7:0] OP_CRC_DATA = 8'h31;
  localparam logic [7:0] OP_VFY_CODE = 8'h40;
  localparam logic [7:0] OP_VFY_DATA = 8'h41;
  localparam logic [7:0] END_MARK    = 8'h3E;

  localparam logic [7:0] STS_OK       = 8'h00;
  localparam logic [7:0] STS_MISMATCH = 8'h01;
  localparam logic [7:0] STS_LOCKED   = 8'h02;
  localparam logic [7:0] STS_BADOP    = 8'h03;

  localparam int HDR_LONG  = 5;
  localparam int HDR_SHORT = 3;

  typedef enum logic [1:0] {K_DUMP, K_CRC, K_VFY} ldr_kind_e;

  typedef enum logic [3:0] {
    S_IDLE, S_HDR, S_PAD, S_FETCH, S_WAIT, S_DOUT, S_VDATA,
    S_CRCGO, S_CRCWAIT, S_CRCLO, S_CRCHI, S_MARK, S_DRAIN
  } ldr_state_e;

  typedef enum logic [2:0] {RS_ZERO, RS_RBUF, RS_CRCL, RS_CRCH, RS_MARK} ldr_rsel_e;

  typedef struct packed {
    logic      known;
    ldr_kind_e kind;
    logic      space;
  } ldr_op_t;

  function automatic ldr_op_t decode_op(input logic [7:0] b);
    ldr_op_t o;
    o = '{known: 1'b1, kind: K_DUMP, space: 1'b1};
    case (b)
      OP_DUMP:     o = '{known: 1'b1, kind: K_DUMP, space: 1'b1};
      OP_CRC_CODE: o = '{known: 1'b1, kind: K_CRC,  space: 1'b0};
      OP_CRC_DATA: o = '{known: 1'b1, kind: K_CRC,  space: 1'b1};
      OP_VFY_CODE: o = '{known: 1'b1, kind: K_VFY,  space: 1'b0};
      OP_VFY_DATA: o = '{known: 1'b1, kind: K_VFY,  space: 1'b1};
      default:     o = '{known: 1'b0, kind: K_DUMP, space: 1'b0};
    endcase
    return o;
  endfunction

endpackage

// File: rtl/ldr_fields.sv
module ldr_fields
  import ldr_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_op,
  input  ldr_op_t           op_in,
  input  logic              hdr_acc,
  input  logic [7:0]        hdr_byte,
  input  logic              step,
  output ldr_kind_e         kind_q,
  output logic              space_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [LEN_W-1:0]  len_q,
  output logic              hdr_last,
  output logic              len_zero,
  output logic              len_one
);

  localparam int IDX_W = $clog2(HDR_LONG + 1);

  logic [IDX_W-1:0]  idx_q, idx_n;
  logic [ADDR_W-1:0] addr_n;
  logic [LEN_W-1:0]  len_n;
  ldr_kind_e         kind_n;
  logic              space_n;

  always_comb begin
    idx_n   = idx_q;
    addr_n  = addr_q;
    len_n   = len_q;
    kind_n  = kind_q;
    space_n = space_q;
    if (cap_op) begin
      idx_n   = '0;
      len_n   = '0;
      kind_n  = op_in.kind;
      space_n = op_in.space;
    end else if (hdr_acc) begin
      idx_n = idx_q + 1'b1;
      case (idx_q)
        IDX_W'(0): if (kind_q == K_VFY) len_n[7:0] = hdr_byte;
        IDX_W'(1): addr_n[7:0] = hdr_byte;
        IDX_W'(2): addr_n[ADDR_W-1:8] = hdr_byte[ADDR_W-9:0];
        IDX_W'(3): len_n[7:0] = hdr_byte;
        IDX_W'(4): len_n[LEN_W-1:8] = hdr_byte[LEN_W-9:0];
        default: ;
      endcase
    end else if (step) begin
      addr_n = addr_q + 1'b1;
      len_n  = len_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q   <= '0;
      addr_q  <= '0;
      len_q   <= '0;
      kind_q  <= K_DUMP;
      space_q <= 1'b0;
    end else begin
      idx_q   <= idx_n;
      addr_q  <= addr_n;
      len_q   <= len_n;
      kind_q  <= kind_n;
      space_q <= space_n;
    end
  end

  assign hdr_last = (kind_q == K_VFY) ? (idx_q == IDX_W'(HDR_SHORT - 1))
                                      : (idx_q == IDX_W'(HDR_LONG - 1));
  assign len_zero = (len_q == '0);
  assign len_one  = (len_q == LEN_W'(1));

endmodule

// File: rtl/ldr_seq.sv
module ldr_seq
  import ldr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic [7:0] in_data,
  input  logic       unlocked,
  input  logic       eof_strobe,
  input  logic       crc_done,
  input  ldr_kind_e  kind,
  input  logic       hdr_last,
  input  logic       len_zero,
  input  logic       len_one,
  output ldr_state_e st_q,
  output logic       in_ready,
  output logic       acc,
  output logic       mem_rd_en,
  output logic       crc_start,
  output logic       cap_op,
  output ldr_op_t    op,
  output logic       hdr_acc,
  output logic       step,
  output logic       cap_rbuf,
  output logic       cap_crc,
  output logic       cmp_en,
  output ldr_rsel_e  rsel,
  output logic       fin,
  output logic       refuse,
  output logic [7:0] refuse_code
);

  ldr_state_e st_n;

  assign in_ready = !(st_q inside {S_FETCH, S_WAIT, S_CRCGO, S_CRCWAIT});
  assign acc      = in_valid && in_ready;
  assign op       = decode_op(in_data);

  always_comb begin
    st_n        = st_q;
    mem_rd_en   = 1'b0;
    crc_start   = 1'b0;
    cap_op      = 1'b0;
    hdr_acc     = 1'b0;
    step        = 1'b0;
    cap_rbuf    = 1'b0;
    cap_crc     = 1'b0;
    cmp_en      = 1'b0;
    rsel        = RS_ZERO;
    fin         = 1'b0;
    refuse      = 1'b0;
    refuse_code = STS_OK;
    case (st_q)
      S_IDLE: if (acc) begin
        if (!op.known) begin
          refuse      = 1'b1;
          refuse_code = STS_BADOP;
          st_n        = S_DRAIN;
        end else if (!unlocked) begin
          refuse      = 1'b1;
          refuse_code = STS_LOCKED;
          st_n        = S_DRAIN;
        end else begin
          cap_op = 1'b1;
          st_n   = S_HDR;
        end
      end
      S_HDR: if (acc) begin
        hdr_acc = 1'b1;
        if (hdr_last) begin
          if (kind == K_VFY) st_n = len_zero ? S_PAD : S_FETCH;
          else               st_n = S_PAD;
        end
      end
      S_PAD: if (acc) begin
        case (kind)
          K_DUMP:  st_n = len_zero ? S_MARK : S_FETCH;
          K_CRC:   st_n = len_zero ? S_MARK : S_CRCGO;
          default: st_n = S_MARK;
        endcase
      end
      S_FETCH: begin
        mem_rd_en = 1'b1;
        st_n      = S_WAIT;
      end
      S_WAIT: begin
        cap_rbuf = 1'b1;
        st_n     = (kind == K_VFY) ? S_VDATA : S_DOUT;
      end
      S_DOUT: begin
        rsel = RS_RBUF;
        if (acc) begin
          step = 1'b1;
          st_n = len_one ? S_MARK : S_FETCH;
        end
      end
      S_VDATA: if (acc) begin
        cmp_en = 1'b1;
        step   = 1'b1;
        st_n   = len_one ? S_PAD : S_FETCH;
      end
      S_CRCGO: begin
        crc_start = 1'b1;
        st_n      = S_CRCWAIT;
      end
      S_CRCWAIT: if (crc_done) begin
        cap_crc = 1'b1;
        st_n    = S_CRCLO;
      end
      S_CRCLO: begin
        rsel = RS_CRCL;
        if (acc) st_n = S_CRCHI;
      end
      S_CRCHI: begin
        rsel = RS_CRCH;
        if (acc) st_n = S_MARK;
      end
      S_MARK: begin
        rsel = RS_MARK;
        if (acc) begin
          fin  = 1'b1;
          st_n = S_IDLE;
        end
      end
      S_DRAIN: if (eof_strobe) st_n = S_IDLE;
      default: st_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= S_IDLE;
    else        st_q <= st_n;
  end

endmodule

// File: rtl/ldr_reply.sv
module ldr_reply
  import ldr_pkg::*;
#(
  parameter int CRC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             resp_en,
  input  ldr_rsel_e        rsel,
  input  logic             cap_rbuf,
  input  logic [7:0]       mem_rd_data,
  input  logic             cap_crc,
  input  logic [CRC_W-1:0] crc_result,
  input  logic             clr_mism,
  input  logic             cmp_en,
  input  logic [7:0]       in_data,
  input  logic             fin,
  input  logic             refuse,
  input  logic [7:0]       refuse_code,
  output logic             out_valid,
  output logic [7:0]       out_data,
  output logic [7:0]       status
);

  logic [7:0]       rbuf_q, rbuf_n;
  logic [CRC_W-1:0] crc_q, crc_n;
  logic             mism_q, mism_n;
  logic             ov_n;
  logic [7:0]       od_n, sts_n;

  always_comb begin
    ov_n = resp_en;
    od_n = out_data;
    if (resp_en) begin
      case (rsel)
        RS_RBUF: od_n = rbuf_q;
        RS_CRCL: od_n = crc_q[7:0];
        RS_CRCH: od_n = crc_q[CRC_W-1:8];
        RS_MARK: od_n = END_MARK;
        default: od_n = 8'h00;
      endcase
    end
    rbuf_n = cap_rbuf ? mem_rd_data : rbuf_q;
    crc_n  = cap_crc ? crc_result : crc_q;
    mism_n = mism_q;
    if (clr_mism)                            mism_n = 1'b0;
    else if (cmp_en && (in_data != rbuf_q))  mism_n = 1'b1;
    sts_n = status;
    if (refuse)   sts_n = refuse_code;
    else if (fin) sts_n = mism_q ? STS_MISMATCH : STS_OK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= 8'h00;
      rbuf_q    <= 8'h00;
      crc_q     <= '0;
      mism_q    <= 1'b0;
      status    <= STS_OK;
    end else begin
      out_valid <= ov_n;
      out_data  <= od_n;
      rbuf_q    <= rbuf_n;
      crc_q     <= crc_n;
      mism_q    <= mism_n;
      status    <= sts_n;
    end
  end

endmodule

// File: rtl/ldr_frame_handler.sv
module ldr_frame_handler
  import ldr_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int LEN_W  = 16,
  parameter int CRC_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              unlocked,
  input  logic              eof_strobe,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  output logic              in_ready,
  output logic              out_valid,
  output logic [7:0]        out_data,
  output logic [7:0]        status,
  output logic              mem_rd_en,
  output logic              mem_space,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [7:0]        mem_rd_data,
  output logic              crc_start,
  output logic              crc_space,
  output logic [ADDR_W-1:0] crc_addr,
  output logic [LEN_W-1:0]  crc_len,
  input  logic              crc_done,
  input  logic [CRC_W-1:0]  crc_result
);

  ldr_state_e        st;
  ldr_kind_e         kind;
  ldr_op_t           op;
  ldr_rsel_e         rsel;
  logic              acc, cap_op, hdr_acc, step, cap_rbuf, cap_crc, cmp_en;
  logic              fin, refuse, hdr_last, len_zero, len_one, space_q;
  logic [7:0]        refuse_code;
  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0]  len_q;

  ldr_seq u_seq (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .unlocked(unlocked), .eof_strobe(eof_strobe), .crc_done(crc_done),
    .kind(kind), .hdr_last(hdr_last), .len_zero(len_zero), .len_one(len_one),
    .st_q(st), .in_ready(in_ready), .acc(acc), .mem_rd_en(mem_rd_en),
    .crc_start(crc_start), .cap_op(cap_op), .op(op), .hdr_acc(hdr_acc),
    .step(step), .cap_rbuf(cap_rbuf), .cap_crc(cap_crc), .cmp_en(cmp_en),
    .rsel(rsel), .fin(fin), .refuse(refuse), .refuse_code(refuse_code)
  );

  ldr_fields #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_fields (
    .clk(clk), .rst_n(rst_n), .cap_op(cap_op), .op_in(op),
    .hdr_acc(hdr_acc), .hdr_byte(in_data), .step(step),
    .kind_q(kind), .space_q(space_q), .addr_q(addr_q), .len_q(len_q),
    .hdr_last(hdr_last), .len_zero(len_zero), .len_one(len_one)
  );

  ldr_reply #(.CRC_W(CRC_W)) u_reply (
    .clk(clk), .rst_n(rst_n), .resp_en(acc), .rsel(rsel),
    .cap_rbuf(cap_rbuf), .mem_rd_data(mem_rd_data),
    .cap_crc(cap_crc), .crc_result(crc_result),
    .clr_mism(cap_op), .cmp_en(cmp_en), .in_data(in_data),
    .fin(fin), .refuse(refuse), .refuse_code(refuse_code),
    .out_valid(out_valid), .out_data(out_data), .status(status)
  );

  assign mem_space = space_q;
  assign mem_addr  = addr_q;
  assign crc_space = space_q;
  assign crc_addr  = addr_q;
  assign crc_len   = len_q;

endmodule

// File: rtl/ldr_frame_handler_chk.sv
module ldr_frame_handler_chk
  import ldr_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             unlocked,
  input logic             eof_strobe,
  input logic             in_valid,
  input logic [7:0]       in_data,
  input logic             in_ready,
  input logic             out_valid,
  input logic [7:0]       out_data,
  input logic [7:0]       status,
  input logic             crc_start,
  input logic [LEN_W-1:0] crc_len,
  input ldr_state_e       st
);

  logic acc;
  assign acc = in_valid && in_ready;

  AST_REPLY_EACH_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> out_valid); // R1
  AST_NO_SPURIOUS_REPLY: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> !out_valid); // R1
  AST_HDR_REPLY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && (st == S_IDLE || st == S_HDR || st == S_PAD)) |=> (out_data == 8'h00)); // R2
  AST_MARK_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && st == S_MARK) |=> (out_data == 8'h3E)); // R6
  AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc && (st == S_IDLE || st == S_MARK)) |=> $stable(status)); // R7
  AST_LOCKED_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && st == S_IDLE && !unlocked && decode_op(in_data).known)
      |=> (status == 8'h02 && st == S_DRAIN)); // R8
  AST_BADOP_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && st == S_IDLE && !decode_op(in_data).known) |=> (status == 8'h03)); // R9
  AST_DRAIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DRAIN && !eof_strobe) |=> (st == S_DRAIN)); // R10
  AST_CRC_NONZERO_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    crc_start |-> (crc_len != '0)); // R11

endmodule

bind ldr_frame_handler ldr_frame_handler_chk #(.LEN_W(LEN_W)) u_chk (.*);

// File: tb/ldr_frame_handler_bench.sv
module ldr_frame_handler_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        unlocked = 1'b1;
  logic        eof_strobe = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_data = 8'h00;
  logic        in_ready, out_valid, mem_rd_en, mem_space, crc_start, crc_space;
  logic [7:0]  out_data, status;
  logic [15:0] mem_addr, crc_addr, crc_len;
  logic [7:0]  mem_rd_data = 8'h00;
  logic        crc_done = 1'b0;
  logic [15:0] crc_result = 16'h0000;

  always #2.5 clk = ~clk;

  ldr_frame_handler u_ldr_frame_handler (
    .clk(clk), .rst_n(rst_n), .unlocked(unlocked), .eof_strobe(eof_strobe),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .out_valid(out_valid), .out_data(out_data), .status(status),
    .mem_rd_en(mem_rd_en), .mem_space(mem_space), .mem_addr(mem_addr),
    .mem_rd_data(mem_rd_data), .crc_start(crc_start), .crc_space(crc_space),
    .crc_addr(crc_addr), .crc_len(crc_len), .crc_done(crc_done),
    .crc_result(crc_result)
  );

  logic [7:0] cmem [256];
  logic [7:0] dmem [256];
  int tests = 0, fails = 0, cyc = 0, n_rd = 0, n_starts = 0;
  logic        e_space, e_busy = 1'b0;
  logic [15:0] e_addr, e_len;
  int          e_cnt = 0;

  function automatic logic [7:0] mem_at(input logic sp, input logic [15:0] a);
    return sp ? dmem[a[7:0]] : cmem[a[7:0]];
  endfunction

  function automatic logic [15:0] crc_calc(input logic sp, input logic [15:0] a, input logic [15:0] n);
    logic [15:0] c = 16'h0000;
    for (int i = 0; i < int'(n); i++) begin
      c = c ^ {mem_at(sp, a + 16'(i)), 8'h00};
      for (int k = 0; k < 8; k++) c = c[15] ? ((c << 1) ^ 16'h8005) : (c << 1);
    end
    return c;
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mem_rd_en) begin
      mem_rd_data <= mem_at(mem_space, mem_addr);
      n_rd <= n_rd + 1;
    end
    crc_done <= 1'b0;
    if (crc_start) begin
      e_busy <= 1'b1; e_cnt <= 4; n_starts <= n_starts + 1;
      e_space <= crc_space; e_addr <= crc_addr; e_len <= crc_len;
    end else if (e_busy) begin
      if (e_cnt == 0) begin
        e_busy <= 1'b0; crc_done <= 1'b1;
        crc_result <= crc_calc(e_space, e_addr, e_len);
      end else e_cnt <= e_cnt - 1;
    end
    if (cyc == 150000) begin
      fails = fails + 1;
      $display("FAIL R1 watchdog act=hung exp=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [7:0] b, output logic [7:0] r);
    @(negedge clk);
    in_valid = 1'b1; in_data = b;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    r = out_data;
    check(out_valid, "R1 reply valid", int'(out_valid), 1);
  endtask

  task automatic hdr(input logic [7:0] op, input logic [15:0] a, input logic [15:0] n, input bit long_hdr);
    logic [7:0] r;
    xfer(op, r); check(r == 8'h00, "R2 opcode reply", r, 0);
    if (long_hdr) begin
      xfer(8'h02, r);    check(r == 8'h00, "R2 hdr reply", r, 0);
      xfer(a[7:0], r);   check(r == 8'h00, "R2 hdr reply", r, 0);
      xfer(a[15:8], r);  check(r == 8'h00, "R2 hdr reply", r, 0);
      xfer(n[7:0], r);   check(r == 8'h00, "R2 hdr reply", r, 0);
      xfer(n[15:8], r);  check(r == 8'h00, "R2 hdr reply", r, 0);
    end else begin
      xfer(n[7:0], r);   check(r == 8'h00, "R2 hdr reply", r, 0);
      xfer(a[7:0], r);   check(r == 8'h00, "R2 hdr reply", r, 0);
      xfer(a[15:8], r);  check(r == 8'h00, "R2 hdr reply", r, 0);
    end
  endtask

  task automatic finish_frame(input logic [7:0] exp_sts);
    logic [7:0] r;
    xfer(8'h00, r);
    check(r == 8'h3E, "R6 end marker", r, 8'h3E);
    check(status == exp_sts, "R7 status", status, exp_sts);
  endtask

  task automatic do_dump(input logic [15:0] a, input logic [15:0] n);
    logic [7:0] r;
    int rd0;
    rd0 = n_rd;
    hdr(8'h21, a, n, 1'b1);
    xfer(8'h00, r); check(r == 8'h00, "R2 pad reply", r, 0);
    for (int i = 0; i < int'(n); i++) begin
      xfer(8'h00, r);
      check(r == mem_at(1'b1, a + 16'(i)), "R3 dump byte", r, mem_at(1'b1, a + 16'(i)));
    end
    if (n == 0) check(n_rd == rd0, "R11 zero dump reads", n_rd - rd0, 0);
    finish_frame(8'h00);
  endtask

  task automatic do_crc(input logic [7:0] op, input logic [15:0] a, input logic [15:0] n);
    logic [7:0]  r;
    logic [15:0] c;
    logic        sp;
    int s0;
    sp = op[0];
    s0 = n_starts;
    hdr(op, a, n, 1'b1);
    xfer(8'h00, r); check(r == 8'h00, "R2 pad reply", r, 0);
    if (n != 0) begin
      c = crc_calc(sp, a, n);
      xfer(8'h00, r); check(r == c[7:0], "R4 crc low", r, c[7:0]);
      check(e_space == sp && e_addr == a && e_len == n, "R4 crc args", {e_space, e_addr}, {sp, a});
      xfer(8'h00, r); check(r == c[15:8], "R4 crc high", r, c[15:8]);
    end else begin
      check(n_starts == s0, "R11 zero crc start", n_starts - s0, 0);
    end
    finish_frame(8'h00);
  endtask

  task automatic do_vfy(input logic [7:0] op, input logic [15:0] a, input logic [7:0] n, input int bad);
    logic [7:0] r, v;
    logic sp;
    sp = op[0];
    hdr(op, a, {8'h00, n}, 1'b0);
    for (int i = 0; i < int'(n); i++) begin
      v = mem_at(sp, a + 16'(i));
      if (i == bad) v = v ^ 8'h5A;
      xfer(v, r);
    end
    xfer(8'h00, r); check(r == 8'h00, "R5 pad reply", r, 0);
    finish_frame((bad >= 0 && bad < int'(n)) ? 8'h01 : 8'h00);
  endtask

  task automatic do_refused(input logic [7:0] op, input logic lock, input logic [7:0] exp_sts);
    logic [7:0] r;
    int rd0, s0;
    rd0 = n_rd; s0 = n_starts;
    unlocked = !lock;
    xfer(op, r);
    check(status == exp_sts, exp_sts == 8'h02 ? "R8 locked code" : "R9 bad opcode", status, exp_sts);
    for (int i = 0; i < 4; i++) begin
      xfer(8'h21, r); check(r == 8'h00, "R10 drain reply", r, 0);
    end
    check(n_rd == rd0 && n_starts == s0, "R10 drain no action", n_rd - rd0, 0);
    check(status == exp_sts, "R10 status held", status, exp_sts);
    @(negedge clk); eof_strobe = 1'b1;
    @(negedge clk); eof_strobe = 1'b0;
    unlocked = 1'b1;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 256; i++) begin
      cmem[i] = 8'($urandom);
      dmem[i] = 8'($urandom);
    end
    repeat (3) @(negedge clk);
    check(in_ready == 1'b1 && out_valid == 1'b0, "R1 reset ready", {in_ready, out_valid}, 2'b10);
    check(status == 8'h00, "R7 reset status", status, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(mem_rd_en == 1'b0 && crc_start == 1'b0, "R1 reset idle", {mem_rd_en, crc_start}, 0);

    do_dump(16'h0010, 16'd5);
    do_dump(16'hFFFE, 16'd4);
    do_dump(16'h0040, 16'd0);
    do_dump(16'h0080, 16'd1);
    do_crc(8'h30, 16'h0020, 16'd6);
    do_crc(8'h31, 16'h00F0, 16'd20);
    do_crc(8'h31, 16'h0005, 16'd0);
    do_vfy(8'h40, 16'h0030, 8'd8, -1);
    do_vfy(8'h41, 16'h0030, 8'd8, 0);
    do_vfy(8'h41, 16'h0050, 8'd6, 5);
    do_vfy(8'h40, 16'h0000, 8'd0, -1);
    do_refused(8'h30, 1'b1, 8'h02);
    do_dump(16'h0002, 16'd3);
    do_refused(8'h77, 1'b0, 8'h03);
    do_vfy(8'h40, 16'h0012, 8'd3, -1);

    for (int it = 0; it < 40; it++) begin
      int sel, bad;
      logic [15:0] a;
      logic [7:0]  n;
      sel = int'($urandom % 6);
      a = 16'($urandom);
      n = 8'($urandom % 13);
      bad = ($urandom % 2 == 0) ? -1 : int'($urandom % 14);
      case (sel)
        0: do_dump(a, {8'h00, n});
        1: do_crc(8'h30, a, {8'h00, n});
        2: do_crc(8'h31, a, {8'h00, n});
        3: do_vfy(8'h40, a, n, bad);
        4: do_vfy(8'h41, a, n, bad);
        default: do_refused(8'h41, 1'b1, 8'h02);
      endcase
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule